// File: doc/BRIEF.md
# Disk byte transfer engine

This block moves data one byte at a time between a CPU-facing register set and a serial disk stream. The drive sequencer gives it a single-cycle strobe once per byte period. On that strobe the engine either takes the byte arriving from the medium (read direction) or produces the byte to be recorded (write direction). It also maintains a running 16-bit CRC and tells the CPU through a data-ready flag and an optional interrupt when the next register transfer may happen.

While reading, the engine stays quiet through the zero-filled gap that separates files. The first nonzero byte, the start mark, ends the gap. This start mark is shown in the read-data register but raises no interrupt. After it, every byte is presented. While writing, the CPU supplies each byte through the write-data input. A clear in-data control produces gap fill. Raising the transmit-CRC control replaces the outgoing data with the sealed CRC, low byte first. A status output reports whenever the accumulator is nonzero, so a stream that has been read back together with its own CRC returns to zero.

Top module: `disk_xfer_engine`

## Requirements
- R1: After synchronous reset, `data_ready`, `irq`, `disk_wr_vld` and `crc_err` are 0, and `rd_data` and `disk_wr_byte` are 0x00.
- R2: In read mode (`write_n`=1) with `in_data`=1, the first nonzero disk byte after the gap sets data-ready and is copied to `rd_data`, but it does not set `irq` even when `irq_en`=1. Zero bytes before it change neither `data_ready` nor `rd_data`.
- R3: In read mode, once the start mark has been seen, every later byte (zero or not) sets `data_ready`, is copied to `rd_data`, and sets `irq` when `irq_en`=1.
- R4: In read mode with `in_data`=0, the gap tracking is reset, the CRC accumulator is cleared, and `rd_data` is not updated, even for nonzero disk bytes.
- R5: In read mode with `in_data`=1, the disk byte is folded into the CRC only if `send_crc` was 0 at the previous strobe. The fold processes bits LSB first, shifts right and uses the reflected polynomial 0x8408.
- R6: In write mode (`write_n`=0) with `send_crc`=0 and `in_data`=1, each strobe records `wr_data` on `disk_wr_byte` with a one-cycle `disk_wr_vld`, sets `data_ready`, and sets `irq` when `irq_en`=1.
- R7: In write mode with `send_crc`=0 and `in_data`=0, the recorded byte is 0x00 whatever `wr_data` holds.
- R8: In write mode with `send_crc`=1, the recorded byte is the CRC low byte and the accumulator then shifts right by 8. On the first such strobe after `send_crc` rises, two 0x00 bytes are folded in first. Data-ready is not set.
- R9: `crc_err` is 1 exactly when any of the 16 accumulator bits is 1.
- R10: A pulse on `stat_rd` or `ctrl_wr` clears `data_ready` and `irq` on the next edge. A strobe in the same cycle takes precedence.
- R11: Without a strobe, `rd_data` and `disk_wr_byte` hold their values, and `disk_wr_vld` is 0 on the following cycle.
- R12: `irq` is never 1 while `data_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_stb | input | 1 | Single-cycle byte-period strobe from the drive sequencer |
| write_n | input | 1 | 1 selects read direction, 0 selects write direction |
| in_data | input | 1 | 1 when transferring file data, 0 inside a gap |
| send_crc | input | 1 | Transmit/verify CRC control |
| irq_en | input | 1 | Interrupt enable for byte transfers |
| stat_rd | input | 1 | Status register read pulse (clears flags) |
| ctrl_wr | input | 1 | Control register write pulse (clears flags) |
| disk_rd_byte | input | 8 | Byte arriving from the medium |
| wr_data | input | 8 | CPU write-data register contents |
| rd_data | output | 8 | CPU read-data register |
| data_ready | output | 1 | Byte transfer complete flag |
| irq | output | 1 | Pending byte-transfer interrupt |
| crc_err | output | 1 | Accumulator nonzero |
| disk_wr_byte | output | 8 | Byte to record on the medium |
| disk_wr_vld | output | 1 | One-cycle pulse when `disk_wr_byte` is new |

## Verification
Some properties are checked by assertions on every cycle. These are: the interrupt only appearing with data-ready, the flags clearing after a status read or control write, and the registers holding between strobes. They also cover gap fill being zero, the accumulator clearing inside a gap, the gap tracker arming after a start mark, and the top byte emptying after a CRC shift. Only the bench scenarios can show the sequence-level results. These are: the start mark withheld from the interrupt, and the exact CRC bytes sealed onto a written file. The bench also shows that reading that same file back, with the verify flag raised after the first CRC byte, leaves the error bit clear. A corrupted copy sets it.

// File: rtl/dxe_pkg.sv
package dxe_pkg;
  typedef enum logic [2:0] {
    CRC_HOLD,
    CRC_CLEAR,
    CRC_FOLD,
    CRC_SEAL,
    CRC_SHIFT
  } crc_op_e;
endpackage

// File: rtl/dxe_crc_unit.sv
module dxe_crc_unit
  import dxe_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CRC_W  = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8408
) (
  input  logic              clk,
  input  logic              rst,
  input  crc_op_e           op,
  input  logic [DATA_W-1:0] din,
  output logic [CRC_W-1:0]  acc,
  output logic [DATA_W-1:0] tx_byte
);
  // Reflected fold: data enters at the top, one bit per step, LSB first.
  function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] c,
                                            input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic lsb;
    r = c;
    for (int i = 0; i < DATA_W; i++) begin
      lsb = r[0];
      r   = r >> 1;
      if (lsb)  r = r ^ POLY;
      if (d[i]) r[CRC_W-1] = ~r[CRC_W-1];
    end
    return r;
  endfunction

  logic [CRC_W-1:0] sealed;
  assign sealed  = fold(fold(acc, '0), '0);
  assign tx_byte = (op == CRC_SEAL) ? sealed[DATA_W-1:0] : acc[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else begin
      case (op)
        CRC_CLEAR: acc <= '0;
        CRC_FOLD:  acc <= fold(acc, din);
        CRC_SEAL:  acc <= sealed >> DATA_W;
        CRC_SHIFT: acc <= acc >> DATA_W;
        default:   acc <= acc;
      endcase
    end
  end

  // R4: a clear leaves an empty accumulator
  p_crc_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (op == CRC_CLEAR) |=> (acc == '0));

  // R8: after emitting a byte, the top byte is empty
  p_crc_shift_r8: assert property (@(posedge clk) disable iff (rst)
    (op == CRC_SHIFT || op == CRC_SEAL) |=> (acc[CRC_W-1 -: DATA_W] == '0));
endmodule

// File: rtl/dxe_gap_tracker.sv
module dxe_gap_tracker #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb_rd,
  input  logic              stb_wr,
  input  logic              in_data,
  input  logic [DATA_W-1:0] din,
  output logic              covered,
  output logic              covered_nx,
  output logic              start_mark
);
  logic nz;
  assign nz         = (din != '0);
  assign start_mark = stb_rd && in_data && !covered && nz;

  always_comb begin
    if (stb_rd && in_data)     covered_nx = covered || nz;
    else if (stb_rd || stb_wr) covered_nx = 1'b0;
    else                       covered_nx = covered;
  end

  always_ff @(posedge clk) begin
    if (rst) covered <= 1'b0;
    else     covered <= covered_nx;
  end

  // R2: a start mark arms transfer for the following bytes
  p_mark_arms_r2: assert property (@(posedge clk) disable iff (rst)
    start_mark |=> covered);

  // R4: a read strobe inside a gap disarms transfer
  p_gap_disarms_r4: assert property (@(posedge clk) disable iff (rst)
    (stb_rd && !in_data) |=> !covered);
endmodule

// File: rtl/disk_xfer_engine.sv
module disk_xfer_engine
  import dxe_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CRC_W  = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_stb,
  input  logic              write_n,
  input  logic              in_data,
  input  logic              send_crc,
  input  logic              irq_en,
  input  logic              stat_rd,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] disk_rd_byte,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_ready,
  output logic              irq,
  output logic              crc_err,
  output logic [DATA_W-1:0] disk_wr_byte,
  output logic              disk_wr_vld
);
  logic              stb_rd, stb_wr;
  logic              prev_crc;
  crc_op_e           crc_op;
  logic [DATA_W-1:0] crc_din;
  logic [CRC_W-1:0]  crc_acc;
  logic [DATA_W-1:0] crc_tx;
  logic [DATA_W-1:0] wr_out;
  logic              gap_cov, gap_cov_nx, start_mark;

  assign stb_rd = byte_stb && write_n;
  assign stb_wr = byte_stb && !write_n;

  always_comb begin
    crc_op  = CRC_HOLD;
    crc_din = disk_rd_byte;
    if (stb_rd) begin
      if (!in_data)       crc_op = CRC_CLEAR;
      else if (!prev_crc) crc_op = CRC_FOLD;
    end else if (stb_wr) begin
      crc_din = wr_data;
      if (send_crc)       crc_op = prev_crc ? CRC_SHIFT : CRC_SEAL;
      else if (!in_data)  crc_op = CRC_CLEAR;
      else                crc_op = CRC_FOLD;
    end
  end

  dxe_crc_unit #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst(rst), .op(crc_op), .din(crc_din),
    .acc(crc_acc), .tx_byte(crc_tx)
  );

  dxe_gap_tracker #(.DATA_W(DATA_W)) u_gap (
    .clk(clk), .rst(rst), .stb_rd(stb_rd), .stb_wr(stb_wr),
    .in_data(in_data), .din(disk_rd_byte),
    .covered(gap_cov), .covered_nx(gap_cov_nx), .start_mark(start_mark)
  );

  assign wr_out  = send_crc ? crc_tx : (in_data ? wr_data : '0);
  assign crc_err = |crc_acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_crc     <= 1'b0;
      rd_data      <= '0;
      data_ready   <= 1'b0;
      irq          <= 1'b0;
      disk_wr_byte <= '0;
      disk_wr_vld  <= 1'b0;
    end else begin
      disk_wr_vld <= 1'b0;
      if (stat_rd || ctrl_wr) begin
        data_ready <= 1'b0;
        irq        <= 1'b0;
      end
      if (byte_stb) begin
        prev_crc <= send_crc;
        if (write_n) begin
          if (gap_cov_nx) begin
            data_ready <= 1'b1;
            rd_data    <= disk_rd_byte;
            if (irq_en && !start_mark) irq <= 1'b1;
          end
        end else begin
          disk_wr_vld  <= 1'b1;
          disk_wr_byte <= wr_out;
          if (!send_crc) begin
            data_ready <= 1'b1;
            if (irq_en) irq <= 1'b1;
          end
        end
      end
    end
  end

  // R12: interrupt only alongside data-ready
  p_irq_with_ready_r12: assert property (@(posedge clk) disable iff (rst)
    irq |-> data_ready);

  // R10: status read or control write clears the flags
  p_flags_clear_r10: assert property (@(posedge clk) disable iff (rst)
    ((stat_rd || ctrl_wr) && !byte_stb) |=> (!data_ready && !irq));

  // R11: registers hold between strobes
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !byte_stb |=> ($stable(rd_data) && $stable(disk_wr_byte) && !disk_wr_vld));

  // R7: gap fill is recorded as zero
  p_gap_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (stb_wr && !in_data && !send_crc) |=> (disk_wr_vld && disk_wr_byte == '0));

  // R4: read strobes in a gap leave the read register alone
  p_gap_no_load_r4: assert property (@(posedge clk) disable iff (rst)
    (stb_rd && !in_data) |=> $stable(rd_data));
endmodule

// File: tb/disk_xfer_engine_test.sv
`timescale 1ns/1ps
module disk_xfer_engine_test;
  typedef struct {
    string      tag;
    logic       rdy;
    logic       irq;
    logic [7:0] rd;
    logic [7:0] wb;
    logic       wv;
    logic       err;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_stb = 1'b0, write_n = 1'b1, in_data = 1'b0, send_crc = 1'b0;
  logic irq_en = 1'b0, stat_rd = 1'b0, ctrl_wr = 1'b0;
  logic [7:0] disk_rd_byte = 8'h00, wr_data = 8'h00;
  logic [7:0] rd_data, disk_wr_byte;
  logic data_ready, irq, crc_err, disk_wr_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb[$];
  event pushed;

  // model state
  logic       m_gap = 0, m_prev = 0, m_rdy = 0, m_irq = 0, m_wv = 0;
  logic [15:0] m_crc = 0;
  logic [7:0] m_rd = 0, m_wb = 0;
  logic [7:0] rec[8];

  always #4 clk = ~clk;

  disk_xfer_engine uut (
    .clk(clk), .rst(rst), .byte_stb(byte_stb), .write_n(write_n),
    .in_data(in_data), .send_crc(send_crc), .irq_en(irq_en),
    .stat_rd(stat_rd), .ctrl_wr(ctrl_wr), .disk_rd_byte(disk_rd_byte),
    .wr_data(wr_data), .rd_data(rd_data), .data_ready(data_ready),
    .irq(irq), .crc_err(crc_err), .disk_wr_byte(disk_wr_byte),
    .disk_wr_vld(disk_wr_vld)
  );

  // 17-bit formulation of the reflected 0x8408 CRC
  function automatic logic [15:0] mfold(input logic [15:0] c, input logic [7:0] d);
    logic [16:0] x;
    x = {1'b0, c};
    for (int i = 0; i < 8; i++) begin
      if (d[i]) x[16] = 1'b1;
      if (x[0]) x = x ^ 17'h10810;
      x = x >> 1;
    end
    return x[15:0];
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.tag = tag; e.rdy = m_rdy; e.irq = m_irq; e.rd = m_rd;
    e.wb = m_wb; e.wv = m_wv; e.err = (m_crc != 16'h0000);
    sb.push_back(e);
    -> pushed;
  endtask

  task automatic strobe(input string tag);
    logic nz, mark;
    @(negedge clk);
    byte_stb = 1'b1;
    if (write_n) begin
      nz = (disk_rd_byte != 0);
      mark = in_data && !m_gap && nz;
      if (!in_data) m_crc = 0;
      else if (!m_prev) m_crc = mfold(m_crc, disk_rd_byte);
      m_gap = in_data ? (m_gap || nz) : 1'b0;
      if (m_gap) begin
        m_rdy = 1; m_rd = disk_rd_byte;
        if (irq_en && !mark) m_irq = 1;
      end
      m_wv = 0;
    end else begin
      if (send_crc) begin
        if (!m_prev) m_crc = mfold(mfold(m_crc, 8'h00), 8'h00);
        m_wb = m_crc[7:0];
        m_crc = m_crc >> 8;
      end else begin
        m_wb = in_data ? wr_data : 8'h00;
        m_crc = in_data ? mfold(m_crc, m_wb) : 16'h0000;
        m_rdy = 1;
        if (irq_en) m_irq = 1;
      end
      m_wv = 1; m_gap = 0;
    end
    m_prev = send_crc;
    @(posedge clk); #1;
    byte_stb = 1'b0;
    push(tag);
  endtask

  task automatic clear_flags(input string tag, input bit use_ctrl);
    @(negedge clk);
    if (use_ctrl) ctrl_wr = 1'b1; else stat_rd = 1'b1;
    m_rdy = 0; m_irq = 0; m_wv = 0;
    @(posedge clk); #1;
    ctrl_wr = 1'b0; stat_rd = 1'b0;
    push(tag);
  endtask

  task automatic rd_byte(input string tag, input logic [7:0] b);
    disk_rd_byte = b;
    strobe(tag);
  endtask

  task automatic wr_byte(input string tag, input logic [7:0] b);
    wr_data = b;
    strobe(tag);
  endtask

  // monitor: compare every expected item against the ports
  initial begin
    exp_t e;
    forever begin
      @(pushed);
      while (sb.size() != 0) begin
        e = sb.pop_front();
        checks++;
        if (data_ready !== e.rdy || irq !== e.irq || rd_data !== e.rd ||
            disk_wr_byte !== e.wb || disk_wr_vld !== e.wv || crc_err !== e.err) begin
          errors++;
          $display("FAIL %s: got rdy=%b irq=%b rd=%h wb=%h wv=%b err=%b exp rdy=%b irq=%b rd=%h wb=%h wv=%b err=%b",
                   e.tag, data_ready, irq, rd_data, disk_wr_byte, disk_wr_vld, crc_err,
                   e.rdy, e.irq, e.rd, e.wb, e.wv, e.err);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    push("R1 reset state");

    // read: gap with in_data clear, even nonzero bytes ignored
    write_n = 1; in_data = 0; irq_en = 1;
    rd_byte("R4 gap zero", 8'h00);
    rd_byte("R4 gap nonzero ignored", 8'h55);
    in_data = 1;
    rd_byte("R2 zero before mark", 8'h00);
    rd_byte("R2 start mark no irq", 8'h80);
    clear_flags("R10 status read clears", 0);
    rd_byte("R3 data byte irq", 8'h12);
    rd_byte("R3 zero data byte", 8'h00);
    clear_flags("R10 control write clears", 1);
    irq_en = 0;
    rd_byte("R3 irq disabled", 8'hA5);
    repeat (3) @(negedge clk);
    push("R11 hold without strobe");

    // write: gap fill, file data, sealed CRC
    clear_flags("R10 clear before write", 1);
    write_n = 0; in_data = 0; irq_en = 1;
    wr_byte("R7 gap fill zero", 8'h77);
    in_data = 1;
    wr_byte("R6 write mark", 8'h80); rec[0] = m_wb;
    wr_byte("R6 write data", 8'h3C); rec[1] = m_wb;
    clear_flags("R10 clear in write", 0);
    wr_byte("R6 write data", 8'hC3); rec[2] = m_wb;
    wr_byte("R6 write data", 8'h01); rec[3] = m_wb;
    clear_flags("R10 clear before crc", 0);
    send_crc = 1;
    wr_byte("R8 crc low byte", 8'hEE); rec[4] = m_wb;
    wr_byte("R8 crc high byte, R9 empty", 8'hEE); rec[5] = m_wb;
    send_crc = 0; in_data = 0;
    wr_byte("R7 trailing gap", 8'h99);

    // read back and verify
    write_n = 1; in_data = 0;
    rd_byte("R4 read gap clears", 8'h00);
    in_data = 1;
    rd_byte("R2 read gap zero", 8'h00);
    for (int i = 0; i < 5; i++) rd_byte("R5 readback", rec[i]);
    send_crc = 1;
    rd_byte("R5 R9 crc verifies", rec[5]);
    rd_byte("R5 fold skipped after verify", 8'hFF);
    send_crc = 0; in_data = 0;
    rd_byte("R4 clear again", 8'h00);
    in_data = 1;
    rd_byte("R5 mark", rec[0]);
    rd_byte("R5 corrupted byte", rec[1] ^ 8'h04);
    for (int i = 2; i < 5; i++) rd_byte("R5 readback corrupt", rec[i]);
    send_crc = 1;
    rd_byte("R9 crc error flagged", rec[5]);
    send_crc = 0;

    if (rec[0] !== 8'h80 || rec[3] !== 8'h01) begin
      errors++;
      $display("FAIL R6 recorded: got %h %h exp 80 01", rec[0], rec[3]);
    end
    checks++;

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule